// File: doc/BRIEF.md
# Dual-Bank Configurable Interrupt Controller

This block collects a set of external interrupt lines and turns them into two processor requests: a normal request and a fast request. Each request comes from its own bank of registers. A bank holds an enable mask, a per-line trigger mode and a per-line polarity, so every line can be set up as active-high, active-low, rising-edge or falling-edge. The two banks see the same synchronised inputs and are configured independently.

Software reaches the banks through a simple synchronous register bus that is addressed by byte offset. Writes take effect on the clock edge. Reads return combinationally. A line handler reads the masked status of a bank and serves the lowest set bit. For edge-triggered lines it then acknowledges the line by writing a one to that bit in the bank's acknowledge register. It repeats this until status reads zero. Priority and vectoring are left to software.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, every mask, mode and polarity register of both banks reads zero, both status registers read zero and both request outputs are low.
- R2: Bank 0 (normal) occupies offsets 0x00..0x14 and bank 1 (fast) occupies 0x20..0x34. Within a bank the word offsets are: raw source +0x00, mask +0x04, acknowledge +0x08, mode +0x0C, polarity +0x10, status +0x14. The acknowledge offset reads zero. Unaligned offsets, offsets 0x18/0x1C/0x38/0x3C and offsets from 0x40 upward read zero.
- R3: The raw source offset of either bank returns the input lines after SYNC_STAGES clock edges, and not earlier.
- R4: A line with mode bit 0 is level-triggered. Polarity 0 makes it pending while the input is high, and polarity 1 makes it pending while the input is low. Pending follows the input with no memory.
- R5: A line with mode bit 1 is edge-triggered. Polarity 0 latches a pending bit on a rising edge, and polarity 1 latches it on a falling edge. The bit stays set after the input returns.
- R6: Writing a word to a bank's acknowledge offset clears the edge-pending bit of every line written as 1. Lines written as 0 keep their pending state.
- R7: For a level-triggered line whose input is still active, an acknowledge write has no lasting effect and the line stays pending.
- R8: If a qualifying edge is detected on the same clock edge that acknowledges that line, the line stays pending.
- R9: Bank status equals pending AND mask. A mask bit of 1 enables the line, and a line whose mask bit is 0 never appears in status or on the output.
- R10: A bank's request output is the OR of that bank's status, registered one clock later.
- R11: The two banks are independent, so configuring or acknowledging one bank does not change the status or output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_LINES | Asynchronous interrupt inputs |
| busAddr | input | ADDR_W | Byte offset for read and write |
| busWrEn | input | 1 | Write strobe, takes effect on the clock edge |
| busWrData | input | NUM_LINES | Write data, one bit per line |
| busRdData | output | NUM_LINES | Read data for busAddr, combinational |
| irqOut | output | 1 | Normal request (bank 0) |
| fiqOut | output | 1 | Fast request (bank 1) |

## Verification
The bench builds the block with NUM_LINES=32, ADDR_W=8 and SYNC_STAGES=2, so line 31 and the second bank at 0x20 are both reachable. Every latency the bench expects comes from its own copy of SYNC_STAGES. This includes the source visibility edge and the exact edge on which an edge detection coincides with an acknowledge write, so the race in R8 is hit on purpose rather than by chance. The tests cover all four trigger types, sticky versus transparent pending, partial acknowledges, and masking across both banks.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NUM_BANKS = 2;

  // word index inside a bank, from byte offset bits [4:2]
  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_ACK  = 3'd2,
    SEL_MODE = 3'd3,
    SEL_POL  = 3'd4,
    SEL_STAT = 3'd5
  } regSel_t;

  // write strobes handed from control to one bank datapath
  typedef struct packed {
    logic wrMask;
    logic wrAck;
    logic wrMode;
    logic wrPol;
  } bankStrobe_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] syncNow,
  output logic [N-1:0] syncPrev
);

  logic [STAGES-1:0][N-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain    <= '0;
      syncPrev <= '0;
    end else begin
      chain[0] <= rawIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      syncPrev <= chain[STAGES-1];
    end
  end

  assign syncNow = chain[STAGES-1];

endmodule

// File: rtl/intc_regctl.sv
module intc_regctl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  [ADDR_W-1:0] busAddr,
  input  logic                               busWrEn,
  output bankStrobe_t [NUM_BANKS-1:0]        strobes,
  output regSel_t                            rdSel,
  output logic                               rdBank,
  output logic                               rdHit
);

  logic [2:0] wordIdx;
  logic       upperZero;

  always_comb begin
    wordIdx   = busAddr[4:2];
    upperZero = (busAddr[ADDR_W-1:6] == '0) && (busAddr[1:0] == 2'b00);
    rdBank    = busAddr[5];
    rdSel     = regSel_t'(wordIdx);
    rdHit     = upperZero && (wordIdx <= 3'd5);
    strobes   = '0;
    if (busWrEn && rdHit) begin
      case (wordIdx)
        3'd1:    strobes[rdBank].wrMask = 1'b1;
        3'd2:    strobes[rdBank].wrAck  = 1'b1;
        3'd3:    strobes[rdBank].wrMode = 1'b1;
        3'd4:    strobes[rdBank].wrPol  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strobe,
  input  logic [N-1:0] wrData,
  input  logic [N-1:0] syncNow,
  input  logic [N-1:0] syncPrev,
  output logic [N-1:0] maskReg,
  output logic [N-1:0] modeReg,
  output logic [N-1:0] polReg,
  output logic [N-1:0] pending,
  output logic [N-1:0] status,
  output logic         reqOut
);

  logic [N-1:0] qualified;
  logic [N-1:0] edgeHit;
  logic [N-1:0] ackBits;
  logic [N-1:0] pendNext;

  always_comb begin
    qualified = syncNow ^ polReg;
    edgeHit   = (syncNow ^ syncPrev) & qualified;
    ackBits   = strobe.wrAck ? wrData : '0;
    // edge lines: a new edge beats an acknowledge; level lines: transparent
    pendNext  = (modeReg & (edgeHit | (pending & ~ackBits)))
              | (~modeReg & qualified);
    status    = pending & maskReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      modeReg <= '0;
      polReg  <= '0;
      pending <= '0;
      reqOut  <= 1'b0;
    end else begin
      if (strobe.wrMask) maskReg <= wrData;
      if (strobe.wrMode) modeReg <= wrData;
      if (strobe.wrPol)  polReg  <= wrData;
      pending <= pendNext;
      reqOut  <= |status;
    end
  end

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_LINES-1:0] busWrData,
  output logic [NUM_LINES-1:0] busRdData,
  output logic                 irqOut,
  output logic                 fiqOut
);

  logic [NUM_LINES-1:0] syncNow;
  logic [NUM_LINES-1:0] syncPrev;

  bankStrobe_t [NUM_BANKS-1:0] bankStrobes;
  regSel_t                     rdSel;
  logic                        rdBank;
  logic                        rdHit;

  logic [NUM_BANKS-1:0][NUM_LINES-1:0] bankMask;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] bankMode;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] bankPol;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] bankPend;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] bankStat;
  logic [NUM_BANKS-1:0]                bankReq;

  intc_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .rawIn(irqLines),
    .syncNow(syncNow), .syncPrev(syncPrev)
  );

  intc_regctl #(.ADDR_W(ADDR_W)) uCtl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobes(bankStrobes),
    .rdSel(rdSel), .rdBank(rdBank), .rdHit(rdHit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    intc_bank #(.N(NUM_LINES)) uBank (
      .clk(clk), .rstN(rstN), .strobe(bankStrobes[b]), .wrData(busWrData),
      .syncNow(syncNow), .syncPrev(syncPrev),
      .maskReg(bankMask[b]), .modeReg(bankMode[b]), .polReg(bankPol[b]),
      .pending(bankPend[b]), .status(bankStat[b]), .reqOut(bankReq[b])
    );
  end

  always_comb begin
    busRdData = '0;
    if (rdHit) begin
      case (rdSel)
        SEL_SRC:  busRdData = syncNow;
        SEL_MASK: busRdData = bankMask[rdBank];
        SEL_MODE: busRdData = bankMode[rdBank];
        SEL_POL:  busRdData = bankPol[rdBank];
        SEL_STAT: busRdData = bankStat[rdBank];
        default:  busRdData = '0;
      endcase
    end
  end

  assign irqOut = bankReq[0];
  assign fiqOut = bankReq[1];

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N      = 32,
  parameter int ADDR_W = 8,
  parameter int BANK   = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [N-1:0]      syncNow,
  input logic [N-1:0]      syncPrev,
  input logic [N-1:0]      cfgMask,
  input logic [N-1:0]      cfgMode,
  input logic [N-1:0]      cfgPol,
  input logic [N-1:0]      pending,
  input logic              reqOut,
  input logic              wrAck,
  input logic [N-1:0]      wrData,
  input logic [ADDR_W-1:0] busAddr,
  input logic [N-1:0]      busRdData
);

  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(BANK * 32 + 8);

  logic [N-1:0] ackBits;
  logic [N-1:0] wantEdge;
  assign ackBits  = wrAck ? wrData : '0;
  assign wantEdge = cfgMode & (syncNow ^ syncPrev) & (syncNow ^ cfgPol);

  // R2: acknowledge offset always reads zero
  assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ACK_ADDR) |-> (busRdData == '0));

  // R4: level lines track the qualified input of the previous edge
  assert_level_tracks_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~$past(cfgMode) & (pending ^ $past(syncNow ^ cfgPol))) == '0));

  // R5: a qualifying edge always leaves the line pending
  assert_edge_latches_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(wantEdge) & ~pending) == '0));

  // R6: edge-pending bits not acknowledged stay set
  assert_sticky_unacked_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(cfgMode & pending & ~ackBits) & ~pending) == '0));

  // R8: edge coinciding with its acknowledge keeps the line pending
  assert_edge_beats_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((wantEdge & ackBits) != '0) |=> ((pending & $past(wantEdge & ackBits)) == $past(wantEdge & ackBits)));

  // R9: a fully masked bank drops its request next cycle
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMask == '0) |=> !reqOut);

  // R10: request is last cycle's OR of masked pending
  assert_req_is_or_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (reqOut == (|$past(pending & cfgMask))));

endmodule

bind intc_dual_bank intc_checker #(.N(NUM_LINES), .ADDR_W(ADDR_W), .BANK(0)) chkBank0 (
  .clk(clk), .rstN(rstN), .syncNow(syncNow), .syncPrev(syncPrev),
  .cfgMask(bankMask[0]), .cfgMode(bankMode[0]), .cfgPol(bankPol[0]),
  .pending(bankPend[0]), .reqOut(bankReq[0]), .wrAck(bankStrobes[0].wrAck),
  .wrData(busWrData), .busAddr(busAddr), .busRdData(busRdData)
);

bind intc_dual_bank intc_checker #(.N(NUM_LINES), .ADDR_W(ADDR_W), .BANK(1)) chkBank1 (
  .clk(clk), .rstN(rstN), .syncNow(syncNow), .syncPrev(syncPrev),
  .cfgMask(bankMask[1]), .cfgMode(bankMode[1]), .cfgPol(bankPol[1]),
  .pending(bankPend[1]), .reqOut(bankReq[1]), .wrAck(bankStrobes[1].wrAck),
  .wrData(busWrData), .busAddr(busAddr), .busRdData(busRdData)
);

// File: tb/tb_intc_dual_bank.sv
module tb_intc_dual_bank;

  localparam int N      = 32;
  localparam int AW     = 8;
  localparam int STAGES = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqLines = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [N-1:0]  busWrData = '0;
  logic [N-1:0]  busRdData;
  logic          irqOut;
  logic          fiqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intc_dual_bank #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(STAGES)) dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic settle();
    repeat (STAGES + 4) @(negedge clk);
  endtask

  task automatic clearAll();
    for (int b = 0; b < 2; b++) begin
      busWrite(AW'(b * 32 + 4), '0);
      busWrite(AW'(b * 32 + 12), '0);
      busWrite(AW'(b * 32 + 16), '0);
    end
    irqLines = '0;
    settle();
    busWrite(8'h08, '1);
    busWrite(8'h28, '1);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int b = 0; b < 2; b++) begin
      busRead(AW'(b * 32 + 4), d);  check("R1 mask", d, '0);
      busRead(AW'(b * 32 + 12), d); check("R1 mode", d, '0);
      busRead(AW'(b * 32 + 16), d); check("R1 pol", d, '0);
      busRead(AW'(b * 32 + 20), d); check("R1 status", d, '0);
    end
    check("R1 irqOut", N'(irqOut), '0);
    check("R1 fiqOut", N'(fiqOut), '0);
  endtask

  task automatic t_map();
    logic [N-1:0] d;
    busWrite(8'h04, 32'h1111_0001);
    busWrite(8'h0C, 32'h2222_0002);
    busWrite(8'h10, 32'h4444_0004);
    busWrite(8'h24, 32'h8888_0008);
    busWrite(8'h2C, 32'h0101_0010);
    busWrite(8'h30, 32'h0202_0020);
    busRead(8'h04, d); check("R2 mask bank0", d, 32'h1111_0001);
    busRead(8'h0C, d); check("R2 mode bank0", d, 32'h2222_0002);
    busRead(8'h10, d); check("R2 pol bank0", d, 32'h4444_0004);
    busRead(8'h24, d); check("R2 mask bank1", d, 32'h8888_0008);
    busRead(8'h2C, d); check("R2 mode bank1", d, 32'h0101_0010);
    busRead(8'h30, d); check("R2 pol bank1", d, 32'h0202_0020);
    busRead(8'h08, d); check("R2 ack reads zero", d, '0);
    busRead(8'h28, d); check("R2 ack1 reads zero", d, '0);
    busRead(8'h18, d); check("R2 hole 0x18", d, '0);
    busRead(8'h44, d); check("R2 above 0x40", d, '0);
    busRead(8'h05, d); check("R2 unaligned", d, '0);
    clearAll();
  endtask

  task automatic t_source();
    logic [N-1:0] d;
    @(negedge clk);
    irqLines = 32'hA5A5_0F0F;
    busAddr  = 8'h00;
    repeat (STAGES - 1) @(posedge clk);
    @(negedge clk); d = busRdData;
    check("R3 source early", d, '0);
    @(negedge clk); d = busRdData;
    check("R3 source on time", d, 32'hA5A5_0F0F);
    busRead(8'h20, d); check("R3 source bank1", d, 32'hA5A5_0F0F);
    irqLines = '0;
    settle();
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    busWrite(8'h04, 32'h0000_00FF);
    busWrite(8'h10, 32'h0000_00F0);
    irqLines = 32'h0000_0011; settle();
    busRead(8'h14, d); check("R4 level mixed", d, 32'h0000_00E1);
    check("R4 irqOut high", N'(irqOut), 1);
    irqLines = 32'h0000_0010; settle();
    busRead(8'h14, d); check("R4 level follows", d, 32'h0000_00E0);
    irqLines = 32'h0000_00F0; settle();
    busRead(8'h14, d); check("R4 all inactive", d, '0);
    check("R4 irqOut low", N'(irqOut), 0);
    clearAll();
  endtask

  task automatic t_edge();
    logic [N-1:0] d;
    irqLines = 32'h0000_F000; settle();
    busWrite(8'h0C, 32'h0000_FF00);
    busWrite(8'h10, 32'h0000_F000);
    busWrite(8'h04, 32'h0000_FF00);
    busWrite(8'h08, '1); settle();
    busRead(8'h14, d); check("R5 quiet after ack", d, '0);
    irqLines = 32'h0000_E100; settle();
    busRead(8'h14, d); check("R5 rise and fall", d, 32'h0000_1100);
    irqLines = 32'h0000_F000; settle();
    busRead(8'h14, d); check("R5 sticky", d, 32'h0000_1100);
    busWrite(8'h08, 32'h0000_0100); settle();
    busRead(8'h14, d); check("R6 partial ack", d, 32'h0000_1000);
    busWrite(8'h08, 32'h0000_1000); settle();
    busRead(8'h14, d); check("R6 final ack", d, '0);
    check("R6 irqOut low", N'(irqOut), 0);
    clearAll();
  endtask

  task automatic t_levelAck();
    logic [N-1:0] d;
    busWrite(8'h04, 32'h0000_0001);
    irqLines = 32'h0000_0001; settle();
    busWrite(8'h08, 32'h0000_0001); settle();
    busRead(8'h14, d); check("R7 level survives ack", d, 32'h0000_0001);
    check("R7 irqOut stays", N'(irqOut), 1);
    clearAll();
  endtask

  task automatic t_race();
    logic [N-1:0] d;
    busWrite(8'h0C, 32'h0001_0000);
    busWrite(8'h04, 32'h0001_0000);
    irqLines = 32'h0001_0000; settle();
    irqLines = '0; settle();
    busRead(8'h14, d); check("R8 setup pending", d, 32'h0001_0000);
    @(negedge clk);
    irqLines = 32'h0001_0000;
    repeat (STAGES) @(posedge clk);
    @(negedge clk);
    busAddr = 8'h08; busWrData = 32'h0001_0000; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    settle();
    busRead(8'h14, d); check("R8 edge beats ack", d, 32'h0001_0000);
    clearAll();
  endtask

  task automatic t_banks();
    logic [N-1:0] d;
    irqLines = 32'h8000_0000; settle();
    busWrite(8'h24, 32'h8000_0000);
    check("R10 fiqOut not yet", N'(fiqOut), 0);
    @(negedge clk);
    check("R10 fiqOut one later", N'(fiqOut), 1);
    check("R11 irqOut unaffected", N'(irqOut), 0);
    busRead(8'h14, d); check("R9 masked bank0", d, '0);
    busRead(8'h34, d); check("R11 bank1 status", d, 32'h8000_0000);
    busWrite(8'h04, 32'h8000_0000); settle();
    check("R11 irqOut own mask", N'(irqOut), 1);
    busWrite(8'h24, '0); settle();
    check("R9 fiqOut masked", N'(fiqOut), 0);
    check("R11 irqOut kept", N'(irqOut), 1);
    clearAll();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_source();
    t_level();
    t_edge();
    t_levelAck();
    t_race();
    t_banks();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule